// File: doc/BRIEF.md
# UART FIFO Buffers with Receive Threshold Interrupt

This block holds the transmit and receive byte queues of a 16550-style serial port, together with the write-only control register that sets them up. The host reaches it through one small register port. A write at the data offset queues a byte for transmission, and a read at the data offset takes the oldest received byte. At the control offset, a write programs the control register, while a read returns interrupt identification.

The serializer takes bytes from the transmit side with a pop strobe. The deserializer delivers bytes into the receive side with a push strobe. Neither shift register is modelled. The block raises a receive data-ready interrupt when the receive fill count reaches a programmable threshold, and drops it as soon as the fill count falls below that threshold again.

When FIFO mode is off, each direction behaves as a single-byte holding register. When FIFO mode is on, each direction is a 16-entry queue. Per-direction flushes are one-shot actions taken on a control write.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset, fifo_mode is 0, dma_mode is 1, both counts are 0, rx_irq is 0 and rx_overrun is 0.
- R2: Offset 2 is shared between two registers. A write at offset 2 programs control, and a read there returns identification without popping data. Identification bit 0 is 0 when rx_irq is high and 1 otherwise. Bits 3:1 are 3'b010 when rx_irq is high and 3'b000 otherwise. Bits 7:6 are both equal to fifo_mode. Bits 5:4 are 0.
- R3: Control bits 7:6 select the receive threshold: 0 means 1 byte, 1 means 4, 2 means 8 and 3 means 14. In FIFO mode with rx_irq_en high, rx_irq is 1 exactly when rx_count is at or above the threshold.
- R4: rx_irq falls in the same cycle that rx_count falls below the threshold.
- R5: Writing control bit 2 as 1 (with bit 0 set) empties the transmit side, and bit 1 does the same for the receive side. The other direction is untouched. A flush takes effect once per write, and a later write with these bits at 0 leaves both counts unchanged.
- R6: A control write with bit 0 at 0 turns FIFO mode off and empties both sides. Such a write leaves the threshold and the DMA mode bit unchanged.
- R7: In FIFO mode each side holds up to 16 bytes. A receive push into a full side is dropped and sets rx_overrun. rx_overrun stays set until the receive side is emptied by a flush or by disable.
- R8: A host read at offset 0 with the receive side empty returns the last byte taken and leaves rx_count at 0.
- R9: With FIFO mode off, each side holds at most one byte, and rx_irq is high whenever a received byte is held and rx_irq_en is 1.
- R10: A single control write that sets bit 0 together with a flush bit enables FIFO mode and applies the flush in that cycle.
- R11: Bytes leave each side in arrival order. tx_byte shows the oldest transmit byte whenever tx_empty is 0.
- R12: Control bit 3 sets dma_mode when the write also has bit 0 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_irq_en | input | 1 | Receive data-ready interrupt enable |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe |
| reg_addr | input | 3 | Register offset: 0 data, 2 control/identification |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data (combinational) |
| rx_push | input | 1 | Deserializer delivers a byte |
| rx_byte | input | 8 | Received byte |
| tx_pop | input | 1 | Serializer takes the oldest transmit byte |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_empty | output | 1 | Transmit side holds nothing |
| rx_count | output | 5 | Receive fill count |
| tx_count | output | 5 | Transmit fill count |
| rx_irq | output | 1 | Receive data-ready interrupt |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| fifo_mode | output | 1 | FIFO mode active |
| dma_mode | output | 1 | DMA mode bit |

## Verification
Two kinds of event can land on the same edge. The first is a receive flush coinciding with a deserializer push. The second is a host pop coinciding with a push into a full receive side. The bench drives each pair together on purpose, and also drives an enable-plus-flush write while a byte sits in the single holding register. A queue-based reference model decides the outcome on every clock: flush wins over push, a pop frees room for a simultaneous push, and the held byte is discarded. Long stretches of random traffic then mix all of these against the threshold interrupt.

// File: rtl/uart_fifo_pkg.sv
// Shared constants and types for the UART FIFO block.
// Assumes a byte-wide host port and a three-bit register offset.
package uart_fifo_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd2;

    localparam int CB_EN    = 0;
    localparam int CB_RXCLR = 1;
    localparam int CB_TXCLR = 2;
    localparam int CB_DMA   = 3;

    typedef enum logic [1:0] {
        TRIG_1  = 2'd0,
        TRIG_4  = 2'd1,
        TRIG_8  = 2'd2,
        TRIG_14 = 2'd3
    } trig_code_e;

    // Threshold in bytes for each encoded receive trigger.
    function automatic int trig_level(trig_code_e c);
        case (c)
            TRIG_1:  return 1;
            TRIG_4:  return 4;
            TRIG_8:  return 8;
            default: return 14;
        endcase
    endfunction
endpackage

// File: rtl/uart_fifo_buf.sv
// Circular byte queue with a run-time capacity of DEPTH or one entry.
// Assumes clr dominates push and pop; a pop when empty is ignored and a push
// when full is dropped unless a pop frees a slot in the same cycle.
module uart_fifo_buf #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              limit_one_i,
    input  logic              push_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] head_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              empty_o,
    output logic              drop_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count_q;
    logic              full, pop_ok, push_ok;

    // Full depends on the capacity currently in force.
    assign full    = limit_one_i ? (count_q != '0) : (count_q == CNT_FULL);
    assign empty_o = (count_q == '0);
    assign pop_ok  = pop_i && !empty_o;
    assign push_ok = push_i && (!full || pop_ok);
    assign drop_o  = push_i && !push_ok && !clr_i;
    assign head_o  = mem[rd_ptr];
    assign count_o = count_q;

    // Store an accepted byte at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok && !clr_i) begin
            mem[wr_ptr] <= wdata_i;
        end
    end

    // Advance pointers and count; clear wins over everything.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_FULL); // R7
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> empty_o); // R5
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_i && !pop_i && !clr_i) |=> $stable(count_q)); // R7
    AST_SINGLE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        limit_one_i |-> count_q <= 1); // R9
endmodule

// File: rtl/uart_fcr_decode.sv
// Write-only control register decode. Writes with the enable bit clear only
// switch FIFO mode off; other fields keep their values. Flush outputs are
// single-cycle strobes, asserted also on disable so both queues empty.
module uart_fcr_decode
    import uart_fifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output logic              fifo_en_o,
    output trig_code_e        trig_o,
    output logic              dma_o,
    output logic              rx_clr_o,
    output logic              tx_clr_o
);
    logic       ctrl_wr;
    logic       en_q, dma_q;
    trig_code_e trig_q;
    logic       unused_rsvd;

    assign ctrl_wr     = wr_i && (addr_i == OFS_CTRL);
    assign unused_rsvd = ^wdata_i[5:4];

    // Hold the programmable fields; only enabled writes touch the others.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            dma_q  <= 1'b1;
            trig_q <= TRIG_1;
        end else if (ctrl_wr) begin
            en_q <= wdata_i[CB_EN];
            if (wdata_i[CB_EN]) begin
                dma_q  <= wdata_i[CB_DMA];
                trig_q <= trig_code_e'(wdata_i[7:6]);
            end
        end
    end

    // One-shot flushes: explicit flush bit or a disabling write.
    always_comb begin
        rx_clr_o = ctrl_wr && (!wdata_i[CB_EN] || wdata_i[CB_RXCLR]);
        tx_clr_o = ctrl_wr && (!wdata_i[CB_EN] || wdata_i[CB_TXCLR]);
    end

    assign fifo_en_o = en_q;
    assign trig_o    = trig_q;
    assign dma_o     = dma_q;

    AST_OFF_KEEPS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wdata_i[CB_EN]) |=> ($stable(trig_q) && $stable(dma_q))); // R6
    AST_OFF_WRITE_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wdata_i[CB_EN]) |=> !en_q); // R6
endmodule

// File: rtl/uart_rx_trigger.sv
// Receive data-ready interrupt: threshold compare in FIFO mode, byte-held
// test in holding mode. Combinational from the registered fill count.
module uart_rx_trigger
    import uart_fifo_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  trig_code_e       trig_i,
    input  logic             fifo_en_i,
    input  logic             en_i,
    output logic             irq_o
);
    logic reached;

    // Compare fill against the selected threshold, or any byte when off.
    always_comb begin
        if (fifo_en_i) begin
            reached = int'(count_i) >= trig_level(trig_i);
        end else begin
            reached = (count_i != '0);
        end
        irq_o = en_i && reached;
    end

    AST_IRQ_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (count_i != '0)); // R3
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !irq_o); // R3
endmodule

// File: rtl/uart_fifo_ctrl.sv
// UART transmit/receive queues with control register and threshold interrupt.
// Assumes the host read data is sampled in the same cycle as reg_rd; the pop
// takes effect at the following edge. Shift registers live outside.
module uart_fifo_ctrl
    import uart_fifo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_irq_en,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_byte,
    output logic              tx_empty,
    output logic [CNT_W-1:0]  rx_count,
    output logic [CNT_W-1:0]  tx_count,
    output logic              rx_irq,
    output logic              rx_overrun,
    output logic              fifo_mode,
    output logic              dma_mode
);
    logic              fifo_en, rx_clr, tx_clr, rx_drop, tx_drop_unused;
    logic              rx_empty, host_pop, host_push;
    logic [DATA_W-1:0] rx_head, last_rd_q;
    logic              ovr_q;
    trig_code_e        trig;

    assign host_pop  = reg_rd && (reg_addr == OFS_DATA);
    assign host_push = reg_wr && (reg_addr == OFS_DATA);

    uart_fcr_decode u_fcr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (reg_wr),
        .addr_i    (reg_addr),
        .wdata_i   (reg_wdata),
        .fifo_en_o (fifo_en),
        .trig_o    (trig),
        .dma_o     (dma_mode),
        .rx_clr_o  (rx_clr),
        .tx_clr_o  (tx_clr)
    );

    uart_fifo_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_rxq (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (rx_clr),
        .limit_one_i (!fifo_en),
        .push_i      (rx_push),
        .wdata_i     (rx_byte),
        .pop_i       (host_pop),
        .head_o      (rx_head),
        .count_o     (rx_count),
        .empty_o     (rx_empty),
        .drop_o      (rx_drop)
    );

    uart_fifo_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_txq (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (tx_clr),
        .limit_one_i (!fifo_en),
        .push_i      (host_push),
        .wdata_i     (reg_wdata),
        .pop_i       (tx_pop),
        .head_o      (tx_byte),
        .count_o     (tx_count),
        .empty_o     (tx_empty),
        .drop_o      (tx_drop_unused)
    );

    uart_rx_trigger #(.CNT_W(CNT_W)) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_i   (rx_count),
        .trig_i    (trig),
        .fifo_en_i (fifo_en),
        .en_i      (rx_irq_en),
        .irq_o     (rx_irq)
    );

    // Remember the last byte handed to the host for empty reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_rd_q <= '0;
        end else if (host_pop && !rx_empty) begin
            last_rd_q <= rx_head;
        end
    end

    // Sticky overrun, cleared whenever the receive side is emptied.
    always_ff @(posedge clk) begin
        if (!rst_n || rx_clr) begin
            ovr_q <= 1'b0;
        end else if (rx_drop) begin
            ovr_q <= 1'b1;
        end
    end

    // Read mux: data offset pops, control offset returns identification.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_DATA) begin
            reg_rdata = rx_empty ? last_rd_q : rx_head;
        end else if (reg_addr == OFS_CTRL) begin
            reg_rdata[7:6] = {fifo_en, fifo_en};
            reg_rdata[3:1] = rx_irq ? 3'b010 : 3'b000;
            reg_rdata[0]   = !rx_irq;
        end
    end

    assign rx_overrun = ovr_q;
    assign fifo_mode  = fifo_en;

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !rx_clr) |=> ovr_q); // R7
    AST_EMPTY_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_pop && rx_empty && !rx_push) |=> $stable(last_rd_q)); // R8
endmodule

// File: tb/uart_fifo_ctrl_tb.sv
`timescale 1ns/1ps
module uart_fifo_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n, rx_irq_en, reg_wr, reg_rd, rx_push, tx_pop;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata, rx_byte, tx_byte;
    logic       tx_empty, rx_irq, rx_overrun, fifo_mode, dma_mode;
    logic [4:0] rx_count, tx_count;

    always #4 clk = ~clk;

    uart_fifo_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .rx_irq_en(rx_irq_en),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_push(rx_push), .rx_byte(rx_byte), .tx_pop(tx_pop),
        .tx_byte(tx_byte), .tx_empty(tx_empty), .rx_count(rx_count),
        .tx_count(tx_count), .rx_irq(rx_irq), .rx_overrun(rx_overrun),
        .fifo_mode(fifo_mode), .dma_mode(dma_mode)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state.
    int rxq[$];
    int txq[$];
    bit m_fen = 0;
    int m_thr = 0;
    bit m_dma = 1;
    bit m_ovr = 0;
    int m_last = 0;

    function automatic int lvl(int c);
        case (c)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic bit m_irq();
        if (!rx_irq_en) return 0;
        return m_fen ? (rxq.size() >= lvl(m_thr)) : (rxq.size() > 0);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One clock: drive, check read data, advance model, check outputs.
    task automatic step(bit wr, bit rd, logic [2:0] a, logic [7:0] wd,
                        bit rp, logic [7:0] rb, bit tp);
        bit rclr, tclr, pop_ok, push_ok, irq;
        int cap, exp;
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        rx_push = rp; rx_byte = rb; tx_pop = tp;
        #1;
        irq = m_irq();
        if (rd) begin
            if (a == 3'd0) begin
                exp = (rxq.size() > 0) ? rxq[0] : m_last;
                chk("R8", "rdata", int'(reg_rdata), exp);
            end else if (a == 3'd2) begin
                exp = (m_fen ? 192 : 0) + (irq ? 4 : 1);
                chk("R2", "ident", int'(reg_rdata), exp);
            end
        end
        cap = m_fen ? 16 : 1;
        rclr = 0; tclr = 0;
        if (wr && a == 3'd2) begin
            if (wd[0]) begin
                m_fen = 1; m_thr = int'(wd[7:6]); m_dma = wd[3];
                rclr = wd[1]; tclr = wd[2];
            end else begin
                m_fen = 0; rclr = 1; tclr = 1;
            end
        end
        if (rd && a == 3'd0 && rxq.size() > 0) m_last = rxq[0];
        if (rclr) begin
            rxq.delete(); m_ovr = 0;
        end else begin
            pop_ok  = rd && a == 3'd0 && rxq.size() > 0;
            push_ok = rp && (rxq.size() < cap || pop_ok);
            if (pop_ok) void'(rxq.pop_front());
            if (push_ok) rxq.push_back(int'(rb));
            else if (rp) m_ovr = 1;
        end
        if (tclr) begin
            txq.delete();
        end else begin
            pop_ok  = tp && txq.size() > 0;
            push_ok = wr && a == 3'd0 && (txq.size() < cap || pop_ok);
            if (pop_ok) void'(txq.pop_front());
            if (push_ok) txq.push_back(int'(wd));
        end
        @(posedge clk);
        #1;
        chk("R7", "rx_count", int'(rx_count), rxq.size());
        chk("R5", "tx_count", int'(tx_count), txq.size());
        chk("R6", "fifo_mode", int'(fifo_mode), int'(m_fen));
        chk("R12", "dma_mode", int'(dma_mode), int'(m_dma));
        chk("R7", "rx_overrun", int'(rx_overrun), int'(m_ovr));
        chk("R3", "rx_irq", int'(rx_irq), int'(m_irq()));
        chk("R11", "tx_empty", int'(tx_empty), int'(txq.size() == 0));
        if (txq.size() > 0) chk("R11", "tx_byte", int'(tx_byte), txq[0]);
    endtask

    task automatic idle();              step(0, 0, 3'd0, 8'h00, 0, 8'h00, 0); endtask
    task automatic wctl(logic [7:0] d); step(1, 0, 3'd2, d, 0, 8'h00, 0); endtask
    task automatic rdd();               step(0, 1, 3'd0, 8'h00, 0, 8'h00, 0); endtask
    task automatic rdid();              step(0, 1, 3'd2, 8'h00, 0, 8'h00, 0); endtask
    task automatic rxin(logic [7:0] b); step(0, 0, 3'd0, 8'h00, 1, b, 0); endtask
    task automatic txin(logic [7:0] b); step(1, 0, 3'd0, b, 0, 8'h00, 0); endtask

    // Watchdog ends a hung run as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; rx_irq_en = 1; reg_wr = 0; reg_rd = 0; reg_addr = 0;
        reg_wdata = 0; rx_push = 0; rx_byte = 0; tx_pop = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        // R1 reset state
        chk("R1", "fifo_mode", int'(fifo_mode), 0);
        chk("R1", "dma_mode", int'(dma_mode), 1);
        chk("R1", "counts", int'(rx_count) + int'(tx_count), 0);
        chk("R1", "irq_ovr", int'(rx_irq) + int'(rx_overrun), 0);

        // R9 holding mode: one byte each way, second rx byte overruns
        rxin(8'hA5); rxin(8'h5A); txin(8'h11); txin(8'h22);
        rdid(); rdd(); rdd();           // R8 empty read repeats last byte
        tx_pop = 0; step(0, 0, 3'd0, 8'h00, 0, 8'h00, 1);

        // R10 enable with flush while a byte is held
        rxin(8'h33);
        wctl(8'h0B);
        chk("R10", "rx_count after enable+flush", int'(rx_count), 0);

        // R6 disabling write ignores threshold and dma fields
        wctl(8'hC1);                    // thr 14, dma 0 (R12)
        chk("R12", "dma cleared", int'(dma_mode), 0);
        rxin(8'h01); txin(8'h02);
        wctl(8'h48);                    // bit0=0: disable only
        chk("R6", "dma kept", int'(dma_mode), 0);
        chk("R6", "rx emptied", int'(rx_count), 0);
        rdid();

        // R3/R4 threshold sweep, each enable write flushes both (R10)
        for (int c = 0; c < 4; c++) begin
            wctl(8'((c << 6) | 8'h0F));
            for (int k = 0; k < lvl(c); k++) begin
                rxin(8'(k + 16 * c));
            end
            chk("R3", "irq at threshold", int'(rx_irq), 1);
            rdid();
            rdd();
            chk("R4", "irq below threshold", int'(rx_irq), 0);
        end

        // R7 fill to 16, overflow, then pop+push when full, then order (R11)
        wctl(8'h0B);
        for (int k = 0; k < 17; k++) rxin(8'(8'h40 + k));
        chk("R7", "overrun set", int'(rx_overrun), 1);
        step(0, 1, 3'd0, 8'h00, 1, 8'hEE, 0);
        chk("R7", "full count kept", int'(rx_count), 16);
        for (int k = 0; k < 17; k++) rdd();
        chk("R7", "overrun sticky", int'(rx_overrun), 1);
        // rx flush coincides with a push: flush wins
        step(1, 0, 3'd2, 8'h0B, 1, 8'h99, 0);
        chk("R5", "flush beats push", int'(rx_count), 0);

        // R5 tx flush leaves rx, later write without flush is one-shot
        for (int k = 0; k < 3; k++) txin(8'(k + 1));
        rxin(8'h77); rxin(8'h78);
        wctl(8'h0D);
        chk("R5", "tx flushed", int'(tx_count), 0);
        chk("R5", "rx kept", int'(rx_count), 2);
        txin(8'h55);
        wctl(8'h09);
        chk("R5", "one-shot", int'(tx_count), 1);

        // Random mix, interrupt enable toggling
        for (int n = 0; n < 4000; n++) begin
            int r;
            logic [7:0] d;
            r = $urandom_range(0, 99);
            d = 8'($urandom);
            if (n % 500 == 250) rx_irq_en = !rx_irq_en;
            if (r < 3)       wctl(d | 8'h01);
            else if (r < 4)  wctl(d & 8'hFE);
            else if (r < 30) rxin(d);
            else if (r < 50) rdd();
            else if (r < 65) txin(d);
            else if (r < 80) step(0, 0, 3'd0, 8'h00, 0, 8'h00, 1);
            else if (r < 85) rdid();
            else if (r < 95) step(0, 1, 3'd0, 8'h00, 1, d, 1);
            else             idle();
        end
        idle();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule